// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits between a processor-side 32-bit word bus and the memory or peripheral bus behind it. It lets single bits of two backing regions be read and written through word-sized alias addresses. Each word in an alias window stands for exactly one bit of one word in its backing region. A load from an alias word fetches the backing word and returns the selected bit in bit 0. A store to an alias word becomes a locked read-modify-write that changes only that bit.

Any address outside the two alias windows is forwarded unchanged in the same cycle. This includes direct word accesses to the backing regions. Alias reads are translated and forwarded in the same cycle, so they cost no more than a plain downstream read. Alias writes are run by a small sequencer: it issues a read of the backing word, waits for the data, merges in the new bit and writes the word back. During that sequence the upstream request is stalled and no other downstream access is issued.

The downstream bus accepts a request when `dn_req` and `dn_ready` are both high. It returns read data in order with `dn_rvalid`, at least one cycle after acceptance, with at most one read outstanding.

Top module: `bb_alias_unit`

## Requirements
- R1: An address is an alias address when it lies in 0x22000000–0x23FFFFFC (backing base 0x20000000) or in 0x42000000–0x43FFFFFC (backing base 0x40000000). Addresses just outside these ranges, such as 0x21FFFFFC and 0x24000000, pass through unchanged.
- R2: With off = address − alias base, the backing word address is the backing base + (off[24:7] × 4) and the bit index is off[6:2]. So 0x22000008 selects bit 2 of 0x20000000, and 0x23FFFFFC selects bit 31 of 0x200FFFFC.
- R3: An alias read returns the selected backing bit in up_rdata[0], with up_rdata[31:1] all zero.
- R4: An alias write sets the selected backing bit to up_wdata[0] and leaves the other 31 bits of the backing word unchanged. up_wdata[31:1] has no effect.
- R5: An alias write is performed as a downstream read of the backing word followed by a downstream write of the merged word. up_ready stays low until that write has been accepted, and then rises for one cycle.
- R6: Between the read and the write of an alias write, no other downstream request is issued, and the write goes to the same address as the read.
- R7: A non-alias access drives dn_req, dn_we, dn_addr and dn_wdata from the upstream request in the same cycle. up_ready equals dn_ready for it, and its read data is returned unchanged.
- R8: An alias read issues its translated downstream read in the same cycle it is presented. up_ready equals dn_ready for it, and its result appears together with dn_rvalid.
- R9: After reset, with no request presented, dn_req, up_ready and up_rvalid are low.
- R10: Two back-to-back alias writes to different bits of the same backing word both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Upstream request valid, held until up_ready |
| up_we | input | 1 | Upstream write (1) or read (0) |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_ready | output | 1 | Upstream request accepted this cycle |
| up_rvalid | output | 1 | Upstream read data valid |
| up_rdata | output | 32 | Upstream read data |
| dn_req | output | 1 | Downstream request valid |
| dn_we | output | 1 | Downstream write (1) or read (0) |
| dn_addr | output | 32 | Downstream word address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
A wrong translation shows on dn_addr in the very cycle an alias read is presented. It also shows one downstream acceptance into an alias write, as a read of the wrong word. A corrupted merge or bit-select register shows as a wrong word in the write that follows the read, and at the latest as a wrong bit on the next alias read or direct read of that word. A sequencer that leaves its locked state too early or too late shows as up_ready rising before the write is logged, or as an extra or missing downstream operation between the read and the write.

// File: rtl/bb_pkg.sv
// Shared widths and types for the bit-band alias unit.
package bb_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int BYTE_LSB = $clog2(DATA_W / 8);

    // Read-modify-write sequencer states, in the order they are visited.
    typedef enum logic [2:0] {
        RMW_IDLE,
        RMW_READ,
        RMW_WAIT,
        RMW_WRITE,
        RMW_DONE
    } rmw_state_e;

    // Result of alias decode for one address.
    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] word_addr;
        logic [IDX_W-1:0]  bit_idx;
    } alias_xlate_t;
endpackage

// File: rtl/bb_alias_decode.sv
// Alias window decode and address translation.
// Compares a word address against every alias window and forms the backing
// word address and bit index for the window that matches.
// Assumes each alias base is aligned to its window size and each backing
// base is aligned to its region size, so the offset can be ORed in.
module bb_alias_decode
    import bb_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int REGION_BITS = 20,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000}
) (
    input  logic [ADDR_W-1:BYTE_LSB] word_addr_i,
    output alias_xlate_t             xlate_o
);
    localparam int OFF_W   = REGION_BITS + IDX_W;
    localparam int WSEL_LO = BYTE_LSB + IDX_W;

    logic [NUM_REGIONS-1:0]             hit;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] waddr;
    logic [NUM_REGIONS-1:0][IDX_W-1:0]  bidx;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic [OFF_W-1:BYTE_LSB] off;
        // Window offset above the byte lane bits.
        assign off      = word_addr_i[OFF_W-1:BYTE_LSB];
        // Window match on the bits above the window size.
        assign hit[g]   = (word_addr_i[ADDR_W-1:OFF_W] == ALIAS_BASE[g][ADDR_W-1:OFF_W]);
        // Each run of DATA_W alias words maps onto one backing word.
        assign waddr[g] = REGION_BASE[g] |
                          ADDR_W'({off[OFF_W-1:WSEL_LO], {BYTE_LSB{1'b0}}});
        assign bidx[g]  = off[WSEL_LO-1:BYTE_LSB];
    end

    // Merge the per-window results; windows do not overlap.
    always_comb begin
        xlate_o = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i]) begin
                xlate_o.hit       = 1'b1;
                xlate_o.word_addr = xlate_o.word_addr | waddr[i];
                xlate_o.bit_idx   = xlate_o.bit_idx | bidx[i];
            end
        end
    end
endmodule

// File: rtl/bb_bit_lane.sv
// Single-bit datapath shared by alias reads and alias writes.
// Produces the selected bit moved to bit 0, and the word with the selected
// bit replaced by a new value. Purely combinational.
module bb_bit_lane
    import bb_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] lsb_o,
    output logic [DATA_W-1:0] merged_o
);
    logic [DATA_W-1:0] sel;

    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        // One-hot lane select and per-lane merge.
        assign sel[g]      = (idx_i == IDX_W'(g));
        assign merged_o[g] = sel[g] ? bit_i : word_i[g];
    end

    // Extracted bit placed at bit 0, upper bits zero.
    assign lsb_o = {{(DATA_W-1){1'b0}}, |(word_i & sel)};
endmodule

// File: rtl/bb_rmw_fsm.sv
// Read-modify-write sequencer for alias writes.
// On start it latches the backing address, bit index and bit value. It then
// reads the word, captures the merged word when the data returns, writes it
// back, and signals completion for one cycle.
// Assumes the merged word is computed outside from dn_rdata with idx_o/bit_o,
// and that the caller holds off start while another read is still pending.
module bb_rmw_fsm
    import bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              bit_i,
    input  logic              dn_ready_i,
    input  logic              dn_rvalid_i,
    input  logic [DATA_W-1:0] merged_i,
    output rmw_state_e        state_o,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              bit_o,
    output logic              done_o
);
    rmw_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              bit_q;
    logic [DATA_W-1:0] word_q;

    // Next-state selection for the locked sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RMW_IDLE:  if (start_i)     state_d = RMW_READ;
            RMW_READ:  if (dn_ready_i)  state_d = RMW_WAIT;
            RMW_WAIT:  if (dn_rvalid_i) state_d = RMW_WRITE;
            RMW_WRITE: if (dn_ready_i)  state_d = RMW_DONE;
            RMW_DONE:                   state_d = RMW_IDLE;
            default:                    state_d = RMW_IDLE;
        endcase
    end

    // State register and latched operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RMW_IDLE;
            addr_q  <= '0;
            idx_q   <= '0;
            bit_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RMW_IDLE && start_i) begin
                addr_q <= addr_i;
                idx_q  <= idx_i;
                bit_q  <= bit_i;
            end
            if (state_q == RMW_WAIT && dn_rvalid_i) begin
                word_q <= merged_i;
            end
        end
    end

    // Downstream drive during the sequence.
    always_comb begin
        req_o   = (state_q == RMW_READ) || (state_q == RMW_WRITE);
        we_o    = (state_q == RMW_WRITE);
        addr_o  = addr_q;
        wdata_o = word_q;
        done_o  = (state_q == RMW_DONE);
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;
    assign bit_o   = bit_q;

    // R5: completion lasts one cycle and returns to idle.
    p_done_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RMW_DONE) |=> (state_q == RMW_IDLE));

    // R4: the word written back carries the requested bit value.
    p_write_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RMW_WRITE) |-> (wdata_o[idx_q] == bit_q));
endmodule

// File: rtl/bb_alias_unit.sv
// Bit-band alias access unit (top).
// Forwards ordinary accesses in the same cycle. Translates alias reads and
// extracts the bit from the returned word. Hands alias writes to the RMW
// sequencer, which owns the downstream bus until the write-back completes.
// Assumes in-order downstream read data, at least one cycle after acceptance,
// with at most one read outstanding, and upstream requests held until accepted.
module bb_alias_unit
    import bb_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int REGION_BITS = 20,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              up_we,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_ready,
    output logic              up_rvalid,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_req,
    output logic              dn_we,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ready,
    input  logic              dn_rvalid,
    input  logic [DATA_W-1:0] dn_rdata
);
    alias_xlate_t      xl;
    rmw_state_e        fsm_state;
    logic              fsm_req, fsm_we, fsm_done, fsm_bit;
    logic [ADDR_W-1:0] fsm_addr;
    logic [DATA_W-1:0] fsm_wdata;
    logic [IDX_W-1:0]  fsm_idx;
    logic              busy, pass_en, fsm_start, rd_accept;
    logic              rd_pend_q, rsp_fwd_q, rsp_alias_q;
    logic [IDX_W-1:0]  rsp_idx_q, lane_idx;
    logic [DATA_W-1:0] lane_lsb, lane_merged;
    logic [ADDR_W-1:0] rd_addr_q;

    bb_alias_decode #(
        .NUM_REGIONS (NUM_REGIONS),
        .REGION_BITS (REGION_BITS),
        .REGION_BASE (REGION_BASE),
        .ALIAS_BASE  (ALIAS_BASE)
    ) decode_i (
        .word_addr_i (up_addr[ADDR_W-1:BYTE_LSB]),
        .xlate_o     (xl)
    );

    bb_rmw_fsm rmw_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (fsm_start),
        .addr_i      (xl.word_addr),
        .idx_i       (xl.bit_idx),
        .bit_i       (up_wdata[0]),
        .dn_ready_i  (dn_ready),
        .dn_rvalid_i (dn_rvalid),
        .merged_i    (lane_merged),
        .state_o     (fsm_state),
        .req_o       (fsm_req),
        .we_o        (fsm_we),
        .addr_o      (fsm_addr),
        .wdata_o     (fsm_wdata),
        .idx_o       (fsm_idx),
        .bit_o       (fsm_bit),
        .done_o      (fsm_done)
    );

    // One lane serves both the read extract and the write merge; they never coincide.
    assign lane_idx = (fsm_state == RMW_WAIT) ? fsm_idx : rsp_idx_q;

    bb_bit_lane lane_i (
        .word_i   (dn_rdata),
        .idx_i    (lane_idx),
        .bit_i    (fsm_bit),
        .lsb_o    (lane_lsb),
        .merged_o (lane_merged)
    );

    // Request steering between the pass/alias-read path and the sequencer.
    always_comb begin
        busy      = (fsm_state != RMW_IDLE);
        pass_en   = !busy && up_req && !(xl.hit && up_we);
        fsm_start = !busy && up_req && up_we && xl.hit && !rd_pend_q;
        dn_req    = busy ? fsm_req   : pass_en;
        dn_we     = busy ? fsm_we    : up_we;
        dn_addr   = busy ? fsm_addr  : (xl.hit ? xl.word_addr : up_addr);
        dn_wdata  = busy ? fsm_wdata : up_wdata;
        up_ready  = busy ? fsm_done  : (pass_en && dn_ready);
        rd_accept = dn_req && dn_ready && !dn_we;
    end

    // Response tracking: which read is outstanding and how to return it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q   <= 1'b0;
            rsp_fwd_q   <= 1'b0;
            rsp_alias_q <= 1'b0;
            rsp_idx_q   <= '0;
            rd_addr_q   <= '0;
        end else begin
            if (rd_accept) begin
                rd_pend_q   <= 1'b1;
                rsp_fwd_q   <= !busy;
                rsp_alias_q <= !busy && xl.hit;
                rsp_idx_q   <= xl.bit_idx;
                rd_addr_q   <= dn_addr;
            end else if (dn_rvalid) begin
                rd_pend_q   <= 1'b0;
            end
        end
    end

    // Read return: the sequencer's own read is not forwarded upstream.
    assign up_rvalid = dn_rvalid && rsp_fwd_q;
    assign up_rdata  = rsp_alias_q ? lane_lsb : dn_rdata;

    // R7: ordinary accesses reach the downstream bus in the same cycle.
    p_pass_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && up_req && !xl.hit) |-> (dn_req && dn_we == up_we && dn_addr == up_addr));

    // R8: alias reads are issued downstream in the cycle they appear.
    p_alias_read_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && up_req && !up_we && xl.hit) |-> (dn_req && !dn_we));

    // R3: an alias read result carries nothing above bit 0.
    p_alias_lsb_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rvalid && rsp_alias_q) |-> (up_rdata[DATA_W-1:1] == '0));

    // R5: upstream stays stalled until the write-back has been accepted.
    p_stall_until_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fsm_state != RMW_DONE) |-> !up_ready);

    // R6: nothing is issued downstream while waiting for the read data.
    p_wait_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == RMW_WAIT) |-> !dn_req);

    // R6: the write-back goes to the word that was just read.
    p_same_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == RMW_WRITE) |-> (dn_req && dn_we && dn_addr == rd_addr_q));
endmodule

// File: tb/bb_alias_unit_tb_top.sv
// Scoreboard bench: the driver queues expected read results, a monitor
// compares them as up_rvalid arrives; downstream is a behavioural memory.
module bb_alias_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0, up_we = 1'b0;
    logic [31:0] up_addr = '0, up_wdata = '0;
    logic        up_ready, up_rvalid;
    logic [31:0] up_rdata;
    logic        dn_req, dn_we;
    logic [31:0] dn_addr, dn_wdata;
    logic        dn_ready = 1'b1, dn_rvalid = 1'b0;
    logic [31:0] dn_rdata = '0;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    logic [31:0] dmem [logic [31:0]];
    logic [31:0] rmem [logic [31:0]];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        log_we [$];
    logic [31:0] log_addr [$];
    logic [31:0] log_data [$];

    always #4 clk = ~clk;

    bb_alias_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .up_req(up_req), .up_we(up_we), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_ready(up_ready), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ready(dn_ready), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    function automatic logic [31:0] init_val(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] dmem_rd(logic [31:0] a);
        return dmem.exists(a) ? dmem[a] : init_val(a);
    endfunction

    function automatic logic [31:0] rmem_rd(logic [31:0] a);
        return rmem.exists(a) ? rmem[a] : init_val(a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Downstream memory with a periodic stall; read data one cycle after acceptance.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        dn_ready <= (cyc % 5) != 3;
        if (!rst_n) begin
            dn_rvalid <= 1'b0;
        end else begin
            dn_rvalid <= 1'b0;
            if (dn_req && dn_ready) begin
                log_we.push_back(dn_we);
                log_addr.push_back(dn_addr);
                log_data.push_back(dn_we ? dn_wdata : 32'h0);
                if (dn_we) dmem[dn_addr] = dn_wdata;
                else begin
                    dn_rvalid <= 1'b1;
                    dn_rdata  <= dmem_rd(dn_addr);
                end
            end
        end
    end

    // Monitor: compare each returned read against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && up_rvalid) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rvalid", up_rdata, 32'h0);
            else chk(up_rdata == exp_q[0], tag_q[0], up_rdata, exp_q[0]);
            if (exp_q.size() != 0) begin
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    // Independent view of the alias mapping (R1, R2).
    task automatic xlate(input logic [31:0] a, output bit hit, output logic [31:0] w, output int b);
        logic [31:0] base;
        hit = 1'b1;
        if (a[31:25] == 7'h11)      base = 32'h2000_0000;
        else if (a[31:25] == 7'h21) base = 32'h4000_0000;
        else begin hit = 1'b0; base = 32'h0; end
        w = hit ? (base + {12'h0, a[24:7], 2'b00}) : a;
        b = int'(a[6:2]);
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd, input string req);
        bit hit;
        logic [31:0] w, oldw, neww;
        int b, n0;
        bit r;
        xlate(a, hit, w, b);
        @(negedge clk);
        n0 = log_addr.size();
        up_req = 1'b1; up_we = we; up_addr = a; up_wdata = wd;
        if (!we) begin
            exp_q.push_back(hit ? {31'h0, rmem_rd(w)[b]} : rmem_rd(a));
            tag_q.push_back({req, " read data"});
        end
        #3;
        if (!(hit && we))
            chk(dn_req && dn_addr == w && dn_we == we, {req, " same-cycle dn_addr"}, dn_addr, w);
        else
            chk(!dn_req && !up_ready, "R5 no early forward of alias write", {30'h0, dn_req, up_ready}, 32'h0);
        forever begin
            r = up_ready;
            if (r && hit && we)
                chk(log_addr.size() == n0 + 2, "R5 ready after write-back", log_addr.size(), n0 + 2);
            @(posedge clk);
            if (r) break;
            #7;
        end
        #1;
        up_req = 1'b0;
        if (we && hit) begin
            oldw = rmem_rd(w);
            neww = oldw;
            neww[b] = wd[0];
            if (log_addr.size() >= n0 + 2) begin
                chk(!log_we[n0] && log_addr[n0] == w, "R6 read of backing word", log_addr[n0], w);
                chk(log_we[n0+1] && log_addr[n0+1] == w, "R6 write to same word", log_addr[n0+1], w);
                chk(log_data[n0+1] == neww, {req, " merged word"}, log_data[n0+1], neww);
            end else chk(1'b0, "R6 missing rmw ops", log_addr.size(), n0 + 2);
            rmem[w] = neww;
        end else if (we) begin
            rmem[a] = wd;
        end
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: idle outputs after reset
        chk(!dn_req && !up_ready && !up_rvalid, "R9 reset idle", {29'h0, dn_req, up_ready, up_rvalid}, 32'h0);

        // R7: ordinary accesses pass through
        access(1'b1, 32'h1000_0040, 32'hDEAD_BEEF, "R7");
        access(1'b0, 32'h1000_0040, 32'h0, "R7");
        access(1'b0, 32'h2000_0000, 32'h0, "R7 direct backing");
        // R1: just outside the SRAM alias window
        access(1'b0, 32'h21FF_FFFC, 32'h0, "R1 below window");
        access(1'b0, 32'h2400_0000, 32'h0, "R1 above window");

        // R2 R3 R8: every bit index of the first SRAM word
        for (int i = 0; i < 32; i++) access(1'b0, 32'h2200_0000 + 4 * i, 32'h0, "R3");

        // R4: set bit 2 through alias, check directly
        access(1'b1, 32'h2200_0008, 32'h0000_0001, "R4 set");
        access(1'b0, 32'h2000_0000, 32'h0, "R4 direct after set");
        // R4: upper data bits ignored (bit0 = 0 clears)
        access(1'b1, 32'h2200_0014, 32'hFFFF_FFFE, "R4 ignore upper");
        access(1'b0, 32'h2000_0000, 32'h0, "R4 direct after clear");
        access(1'b0, 32'h2200_0014, 32'h0, "R4 alias after clear");

        // R2: last alias word of SRAM window
        access(1'b1, 32'h23FF_FFFC, 32'h0000_0000, "R2 last word");
        access(1'b0, 32'h23FF_FFFC, 32'h0, "R2 last alias");
        access(1'b0, 32'h200F_FFFC, 32'h0, "R2 last direct");

        // R1 R2: peripheral window, first and last words
        access(1'b1, 32'h4200_0000, 32'h1, "R2 periph first");
        access(1'b0, 32'h4200_0000, 32'h0, "R2 periph first");
        access(1'b1, 32'h43FF_FFFC, 32'h0, "R2 periph last");
        access(1'b0, 32'h400F_FFFC, 32'h0, "R2 periph last direct");

        // R4: write every bit index of one peripheral word
        for (int i = 0; i < 32; i++) access(1'b1, 32'h4200_0200 + 4 * i, {31'h0, i[0]}, "R4 all bits");
        access(1'b0, 32'h4000_0010, 32'h0, "R4 all bits direct");

        // R10: back-to-back alias writes to the same word
        access(1'b1, 32'h2200_081C, 32'h1, "R10 first");
        access(1'b1, 32'h2200_0824, 32'h0, "R10 second");
        access(1'b0, 32'h2000_0040, 32'h0, "R10 combined");
        // R8: alias read right behind an alias write
        access(1'b0, 32'h2200_081C, 32'h0, "R8 read after rmw");
        access(1'b0, 32'h1000_0040, 32'h0, "R7 mixed");
        access(1'b1, 32'h2200_0824, 32'h1, "R10 after read");
        access(1'b0, 32'h2000_0040, 32'h0, "R10 final");

        drain();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule